// File: doc/BRIEF.md
# Parallel I/O Port with DMA Request Routing

This peripheral gives a host bus two 8-bit bidirectional ports and one 8-bit control register. Each port has its own output latch, its own output enable and a direction bit. Reads of a port always return the live pin levels. Because the output latch is not read back, a shorted or overdriven line shows up as a mismatch between the value written and the value read.

The control register also sets up DMA. It picks the transfer trigger, either an internal timer tick input or an external request line that is synchronized and edge-detected. It picks which of two DMA channels receives the request, and it gates DMA as a whole. When a trigger fires, the block raises a request on the selected channel and holds it until that channel acknowledges. In byte mode a transfer moves port A only. In word mode the two ports act as one 16-bit value, with port A as the low byte, and a single acknowledge covers both bytes. Two more control bits drive two auxiliary output pins directly.

Top module: `pio_dma_router`

## Requirements
- R1: Bus offset 0 selects the port A data latch and offset 1 selects the port B data latch. A bus write at either offset updates the latch that drives that port's output pins. Offset 2 is the control register and reads back as written. Offset 3 reads as zero.
- R2: After reset both output enables are low, the control register is zero and both DMA requests are low.
- R3: Control bit 0 drives the port A output enable and bit 1 drives the port B output enable. A value of 1 means output.
- R4: Reading offset 0 or 1 returns the pin input levels, even when the port is an output. A line held low externally reads back as 0 although the latch holds 1.
- R5: Control bits 4 and 5 appear on aux_o[0] and aux_o[1] one cycle after the write.
- R6: Control bit 3 selects the trigger. With bit 3 set, a tick_i high at a clock edge raises the request at that edge. With bit 3 clear, a rising edge of ext_req_i passes through a two-flop synchronizer and an edge detector, so the request rises at the third clock edge after the input rises. A level that stays high does not trigger again.
- R7: Control bit 6 steers the request. A value of 1 drives drq3_o and 0 drives drq1_o. Only the acknowledge of the selected channel is accepted, and at most one request is high at a time.
- R8: Control bit 7 enables DMA. While it is 0, no request is asserted and triggers are ignored. Clearing it drops a pending request at the next edge.
- R9: A raised request stays high until the matching acknowledge is sampled. It then clears, and it stays low for at least one further cycle even if a trigger is present.
- R10: Control bit 2 selects the transfer width, with 1 meaning word and 0 meaning byte. An accepted acknowledge loads dma_wdata_i[7:0] into the port A latch. In word mode only, it also loads dma_wdata_i[15:8] into the port B latch. dma_rdata_o carries the port A pins in its low byte. Its high byte carries the port B pins in word mode and zero in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Bus byte offset |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data (combinational) |
| pa_in_i | input | 8 | Port A pin levels |
| pa_out_o | output | 8 | Port A output latch |
| pa_oe_o | output | 1 | Port A output enable |
| pb_in_i | input | 8 | Port B pin levels |
| pb_out_o | output | 8 | Port B output latch |
| pb_oe_o | output | 1 | Port B output enable |
| aux_o | output | 2 | Auxiliary output levels |
| tick_i | input | 1 | Internal timer tick |
| ext_req_i | input | 1 | External transfer request, asynchronous |
| drq1_o | output | 1 | DMA request, channel 1 |
| drq3_o | output | 1 | DMA request, channel 3 |
| dack1_i | input | 1 | DMA acknowledge, channel 1 |
| dack3_i | input | 1 | DMA acknowledge, channel 3 |
| dma_wdata_i | input | 16 | Data written to the ports by DMA |
| dma_rdata_o | output | 16 | Port data read by DMA |

## Verification
The assertions check four things on every cycle: the two requests are never high together, no request appears while DMA is disabled, a request holds until its own channel acknowledges, and the cycle after an accepted acknowledge is quiet. They also check that a control write reaches the direction and auxiliary outputs one cycle later. The bench scenarios cover what needs chosen stimulus. These are the pin readback with a shorted line, the three-edge latency of the external trigger and its refusal to retrigger on a held level, acknowledges from the wrong channel, and the data that an acknowledge moves in byte and word mode.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned OFS_A    = 0;
  localparam int unsigned OFS_B    = 1;
  localparam int unsigned OFS_CTRL = 2;

  typedef struct packed {
    logic dma_en;
    logic ch3_sel;
    logic aux2;
    logic aux1;
    logic tick_src;
    logic word_mode;
    logic dir_b;
    logic dir_a;
  } ctrl_t;
endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_in_i,
  input  logic [DW-1:0] pb_in_i,
  input  logic          dma_ld_i,
  input  logic [2*DW-1:0] dma_wdata_i,
  output logic [DW-1:0] lat_a_o,
  output logic [DW-1:0] lat_b_o,
  output ctrl_t         ctrl_o
);
  logic [DW-1:0] lat_a_q, lat_b_q;
  ctrl_t         ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_a_q <= '0;
      lat_b_q <= '0;
      ctrl_q  <= '0;
    end else begin
      // bus write takes precedence over a DMA load in the same cycle
      if (wr_en_i && addr_i == AW'(OFS_A))         lat_a_q <= wdata_i;
      else if (dma_ld_i)                            lat_a_q <= dma_wdata_i[DW-1:0];
      if (wr_en_i && addr_i == AW'(OFS_B))         lat_b_q <= wdata_i;
      else if (dma_ld_i && ctrl_q.word_mode)        lat_b_q <= dma_wdata_i[2*DW-1:DW];
      if (wr_en_i && addr_i == AW'(OFS_CTRL))      ctrl_q  <= ctrl_t'(wdata_i[7:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_A):    rdata_o = pa_in_i;
      AW'(OFS_B):    rdata_o = pb_in_i;
      AW'(OFS_CTRL): rdata_o = DW'(ctrl_q);
      default:       rdata_o = '0;
    endcase
  end

  assign lat_a_o = lat_a_q;
  assign lat_b_o = lat_b_q;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/pio_trig.sv
module pio_trig #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_src_i,
  input  logic tick_i,
  input  logic ext_req_i,
  output logic trig_o
);
  logic [SYNC_STAGES:0] sync_q;

  for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= (i == 0) ? ext_req_i : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  logic ext_edge;
  assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign trig_o   = tick_src_i ? tick_i : ext_edge;
endmodule

// File: rtl/pio_dreq.sv
module pio_dreq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ch3_i,
  input  logic trig_i,
  input  logic dack1_i,
  input  logic dack3_i,
  output logic drq1_o,
  output logic drq3_o,
  output logic xfer_o
);
  logic req_q, gap_q, ack_sel;

  assign ack_sel = ch3_i ? dack3_i : dack1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      gap_q <= 1'b0;
    end else if (!en_i) begin
      req_q <= 1'b0;
      gap_q <= 1'b0;
    end else if (req_q && ack_sel) begin
      req_q <= 1'b0;
      gap_q <= 1'b1;
    end else begin
      gap_q <= 1'b0;
      if (!req_q && !gap_q && trig_i) req_q <= 1'b1;
    end
  end

  assign xfer_o = en_i & req_q & ack_sel;
  assign drq1_o = en_i & req_q & ~ch3_i;
  assign drq3_o = en_i & req_q &  ch3_i;
endmodule

// File: rtl/pio_dma_router.sv
module pio_dma_router
  import pio_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_in_i,
  output logic [DW-1:0] pa_out_o,
  output logic          pa_oe_o,
  input  logic [DW-1:0] pb_in_i,
  output logic [DW-1:0] pb_out_o,
  output logic          pb_oe_o,
  output logic [1:0]    aux_o,
  input  logic          tick_i,
  input  logic          ext_req_i,
  output logic          drq1_o,
  output logic          drq3_o,
  input  logic          dack1_i,
  input  logic          dack3_i,
  input  logic [2*DW-1:0] dma_wdata_i,
  output logic [2*DW-1:0] dma_rdata_o
);
  ctrl_t ctrl;
  logic  trig, xfer, dma_en;

  pio_regs #(.DW(DW), .AW(2)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pa_in_i, .pb_in_i,
    .dma_ld_i(xfer), .dma_wdata_i,
    .lat_a_o(pa_out_o), .lat_b_o(pb_out_o), .ctrl_o(ctrl)
  );

  pio_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i, .rst_ni,
    .tick_src_i(ctrl.tick_src), .tick_i, .ext_req_i, .trig_o(trig)
  );

  assign dma_en = ctrl.dma_en;

  pio_dreq u_dreq (
    .clk_i, .rst_ni,
    .en_i(dma_en), .ch3_i(ctrl.ch3_sel), .trig_i(trig),
    .dack1_i, .dack3_i, .drq1_o, .drq3_o, .xfer_o(xfer)
  );

  assign pa_oe_o     = ctrl.dir_a;
  assign pb_oe_o     = ctrl.dir_b;
  assign aux_o       = {ctrl.aux2, ctrl.aux1};
  assign dma_rdata_o = {ctrl.word_mode ? pb_in_i : {DW{1'b0}}, pa_in_i};
endmodule

// File: rtl/pio_dma_router_chk.sv
module pio_dma_router_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          pa_oe_o,
  input logic          pb_oe_o,
  input logic [1:0]    aux_o,
  input logic          drq1_o,
  input logic          drq3_o,
  input logic          dack1_i,
  input logic          dack3_i,
  input logic          dma_en
);
  p_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (pa_oe_o == $past(wdata_i[0]) && pb_oe_o == $past(wdata_i[1])));

  p_aux_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> aux_o == $past(wdata_i[5:4]));

  p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drq1_o, drq3_o}));

  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en |-> !(drq1_o || drq3_o));

  p_hold1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq1_o && !dack1_i && !wr_en_i) |=> drq1_o);

  p_hold3_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq3_o && !dack3_i && !wr_en_i) |=> drq3_o);

  p_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drq1_o && dack1_i) || (drq3_o && dack3_i)) |=> !(drq1_o || drq3_o));
endmodule

bind pio_dma_router pio_dma_router_chk #(.DW(DW)) chk_i (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .pa_oe_o, .pb_oe_o, .aux_o,
  .drq1_o, .drq3_o, .dack1_i, .dack3_i, .dma_en
);

// File: tb/pio_dma_router_tb_top.sv
module pio_dma_router_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] pa_in, pa_out, pb_in, pb_out;
  logic       pa_oe, pb_oe;
  logic [1:0] aux;
  logic       tick = 0, ext_req = 0, drq1, drq3, dack1 = 0, dack3 = 0;
  logic [15:0] dma_wdata = 0, dma_rdata;
  logic [7:0] ext_a = 8'h3C, ext_b = 8'hA5, short_a = 0;

  assign pa_in = pa_oe ? (pa_out & ~short_a) : ext_a;
  assign pb_in = pb_oe ? pb_out : ext_b;

  pio_dma_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pa_in_i(pa_in), .pa_out_o(pa_out), .pa_oe_o(pa_oe),
    .pb_in_i(pb_in), .pb_out_o(pb_out), .pb_oe_o(pb_oe), .aux_o(aux),
    .tick_i(tick), .ext_req_i(ext_req), .drq1_o(drq1), .drq3_o(drq3),
    .dack1_i(dack1), .dack3_i(dack3), .dma_wdata_i(dma_wdata), .dma_rdata_o(dma_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ack1();
    dack1 = 1; @(negedge clk); dack1 = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R2 oe", {pa_oe, pb_oe}, 0);
    chk("R2 drq", {drq1, drq3}, 0);
    bus_rd(2, d); chk("R2 ctrl", d, 0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    bus_rd(0, d); chk("R4 A input pins", d, 8'h3C);
    bus_wr(0, 8'h96); bus_wr(1, 8'h5A);
    chk("R1 A latch", pa_out, 8'h96);
    chk("R1 B latch", pb_out, 8'h5A);
    bus_rd(0, d); chk("R4 A pins while input", d, 8'h3C);
    bus_wr(2, 8'h01);
    chk("R3 dir A", {pb_oe, pa_oe}, 2'b01);
    bus_rd(0, d); chk("R4 A output readback", d, 8'h96);
    bus_rd(1, d); chk("R4 B still input", d, 8'hA5);
    bus_wr(2, 8'h02);
    chk("R3 dir B", {pb_oe, pa_oe}, 2'b10);
    bus_rd(2, d); chk("R1 ctrl readback", d, 8'h02);
    bus_rd(3, d); chk("R1 offset 3", d, 0);
    bus_wr(2, 8'h03);
    short_a = 8'h04; #1;
    bus_rd(0, d); chk("R4 shorted line", d, 8'h92);
    short_a = 0;
    bus_wr(2, 8'h00);
  endtask

  task automatic t_aux();
    bus_wr(2, 8'h10); chk("R5 aux1", aux, 2'b01);
    bus_wr(2, 8'h20); chk("R5 aux2", aux, 2'b10);
    bus_wr(2, 8'h00); chk("R5 aux clear", aux, 2'b00);
  endtask

  task automatic t_tick();
    bus_wr(2, 8'h88);
    chk("R6 idle", drq1, 0);
    tick = 1; @(negedge clk); tick = 0;
    chk("R6 tick raises drq1", {drq1, drq3}, 2'b10);
    cyc(3); chk("R9 hold", drq1, 1);
    dack1 = 1; @(negedge clk); dack1 = 0; tick = 1;
    chk("R9 clear on ack", drq1, 0);
    @(negedge clk); chk("R9 gap cycle", drq1, 0);
    @(negedge clk); tick = 0; chk("R9 re-request after gap", drq1, 1);
    ack1(); cyc(1);
    bus_wr(2, 8'h00);
  endtask

  task automatic t_ext();
    bus_wr(2, 8'h80);
    ext_req = 1;
    cyc(2); chk("R6 ext not yet", drq1, 0);
    cyc(1); chk("R6 ext third edge", drq1, 1);
    ack1(); cyc(4);
    chk("R6 level no retrigger", drq1, 0);
    tick = 1; cyc(2); tick = 0;
    chk("R6 tick ignored in ext mode", drq1, 0);
    ext_req = 0; cyc(3);
    bus_wr(2, 8'h00);
  endtask

  task automatic t_channel();
    bus_wr(2, 8'hC8);
    tick = 1; @(negedge clk); tick = 0;
    chk("R7 drq3 selected", {drq1, drq3}, 2'b01);
    ack1(); chk("R7 wrong ack ignored", drq3, 1);
    dack3 = 1; @(negedge clk); dack3 = 0;
    chk("R7 ch3 ack clears", drq3, 0);
    bus_wr(2, 8'h00);
  endtask

  task automatic t_disable();
    bus_wr(2, 8'h08);
    tick = 1; cyc(3); tick = 0;
    chk("R8 disabled no drq", {drq1, drq3}, 0);
    bus_wr(2, 8'h88);
    chk("R8 stale tick ignored", drq1, 0);
    tick = 1; @(negedge clk); tick = 0;
    chk("R8 enabled drq", drq1, 1);
    bus_wr(2, 8'h08);
    chk("R8 disable drops", {drq1, drq3}, 0);
    bus_wr(2, 8'h00);
  endtask

  task automatic t_word();
    bus_wr(2, 8'h8F);
    tick = 1; @(negedge clk); tick = 0;
    dma_wdata = 16'hBEEF; ack1();
    chk("R10 word A", pa_out, 8'hEF);
    chk("R10 word B", pb_out, 8'hBE);
    chk("R10 word rdata", dma_rdata, 16'hBEEF);
    bus_wr(2, 8'h00);
  endtask

  task automatic t_byte();
    bus_wr(1, 8'h11);
    bus_wr(2, 8'h8B);
    tick = 1; @(negedge clk); tick = 0;
    dma_wdata = 16'h5577; ack1();
    chk("R10 byte A", pa_out, 8'h77);
    chk("R10 byte B untouched", pb_out, 8'h11);
    chk("R10 byte rdata", dma_rdata, 16'h0077);
    bus_wr(2, 8'h00);
  endtask

  initial begin
    cyc(2);
    #2 rst_n = 1;
    cyc(1);
    t_reset();
    t_ports();
    t_aux();
    t_tick();
    t_ext();
    t_channel();
    t_disable();
    t_word();
    t_byte();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule